// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Interface

This block holds the divider settings of a clock synthesizer: a feedback multiplier value M (9 bits), an output divider code N (2 bits) and a two-bit test selector T. Two load paths share it. A parallel path presents pin values directly while its active-low load strobe is low and captures them when the strobe rises. A serial path clocks a 14-bit frame into a shift register. While its load strobe is high, the shift register drives the outputs directly. The values are captured when that strobe falls.

Every pin is sampled on one system clock through two-flop synchronizers, and edges of the serial clock and of both strobes are found by comparing successive synchronized samples. The system clock must run at least four times faster than the serial clock. The test selector steers a TEST output to a constant low, the serial data, the feedback divider clock or the synthesized clock. A master-reset input gates the two clock choices but never touches the stored settings.

Top module: `synth_divcfg`

## Requirements
- R1: While the synchronized parallel strobe `par_ld_n` is low, `m_out`/`n_out` equal the synchronized `par_m`/`par_n` pins, two system clocks after the pins change.
- R2: On a rise of `par_ld_n`, the synchronized `par_m`/`par_n` are stored, and later pin changes leave the outputs unchanged while no serial load is open.
- R3: With `par_ld_n` high, each rising edge of `ser_clk` shifts `ser_dat` into bit 0 of a 14-bit register. A frame is sent first bit first as T1, T0, one spare bit, N1, N0, M8 down to M0, so that M sits in bits 8:0, N in bits 10:9 and T in bits 13:12.
- R4: A rise of `ser_ld` while `par_ld_n` is high opens a serial load. From then on `m_out`, `n_out` and `t_out` show the register fields, including each new shift.
- R5: A fall of `ser_ld` closes an open serial load and stores the register fields. Later shifts do not change the outputs.
- R6: A serial load replaces parallel-stored M and N, and the serial values stay in force until `par_ld_n` goes low again.
- R7: In serial mode `test_out` follows `t_out`: 00 gives 0, 01 gives synchronized `ser_dat`, 10 gives `fb_clk`, 11 gives `syn_clk`.
- R8: `test_out` is 0 whenever the synchronized `par_ld_n` is low.
- R9: `mrst` never changes M, N or T. While synchronized `mrst` is high, selections 10 and 11 drive `test_out` to 0.
- R10: After reset T is 00, and M and N take the `par_m`/`par_n` pin values present during reset.
- R11: `ser_clk` edges while `par_ld_n` is low leave the shift register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_ld_n | input | 1 | Parallel load strobe, low = transparent |
| par_m | input | 9 | Parallel M value |
| par_n | input | 2 | Parallel N code |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial load strobe |
| mrst | input | 1 | Master reset of downstream dividers |
| fb_clk | input | 1 | Feedback divider output, for TEST |
| syn_clk | input | 1 | Synthesized clock, for TEST |
| m_out | output | 9 | Effective M |
| n_out | output | 2 | Effective N code |
| t_out | output | 2 | Effective test selector |
| test_out | output | 1 | TEST pin |

## Verification
Parallel values are swept with the strobe low, then held across pin changes after a rise. This separates transparent from latched behaviour. Serial frames with different field values are shifted with the serial strobe low, then opened and extra bits are shifted. This shows the bit order and that the register stays visible while the load is open. Shifting after the strobe falls, and shifting in parallel mode, shows that stored values and register contents are left untouched. Each test selector value is tried with the data and clock inputs toggling, with and without master reset, to tell the four mux legs and the gating apart.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  typedef enum logic [1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SDATA = 2'b01,
    TSEL_FB    = 2'b10,
    TSEL_SYN   = 2'b11
  } tsel_e;

  localparam int T_W = 2;

  // pick the TEST level for a selector; clock legs gated by master reset
  function automatic logic test_pick(input tsel_e sel, input logic sdata,
                                     input logic fb, input logic syn,
                                     input logic gate);
    logic r;
    case (sel)
      TSEL_SDATA: r = sdata;
      TSEL_FB:    r = fb & ~gate;
      TSEL_SYN:   r = syn & ~gate;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic rise(input logic cur, input logic prv);
    return cur & ~prv;
  endfunction

  function automatic logic fall(input logic cur, input logic prv);
    return ~cur & prv;
  endfunction
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= d;
      q_prev <= d;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      q_prev <= st[STAGES-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/divcfg_shreg.sv
module divcfg_shreg #(
  parameter int FRAME_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  output logic [FRAME_W-1:0] sreg
);
  always_ff @(posedge clk) begin
    if (!rst_n)        sreg <= '0;
    else if (shift_en) sreg <= {sreg[FRAME_W-2:0], din};
  end
endmodule

// File: rtl/divcfg_store.sv
module divcfg_store #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] raw_m,
  input  logic [N_W-1:0] raw_n,
  input  logic           par_latch,
  input  logic [M_W-1:0] par_m_s,
  input  logic [N_W-1:0] par_n_s,
  input  logic           ser_latch,
  input  logic [M_W-1:0] frm_m,
  input  logic [N_W-1:0] frm_n,
  input  logic [T_W-1:0] frm_t,
  output logic [M_W-1:0] hold_m,
  output logic [N_W-1:0] hold_n,
  output logic [T_W-1:0] hold_t
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_m <= raw_m;
      hold_n <= raw_n;
      hold_t <= '0;
    end else if (ser_latch) begin
      hold_m <= frm_m;
      hold_n <= frm_n;
      hold_t <= frm_t;
    end else if (par_latch) begin
      hold_m <= par_m_s;
      hold_n <= par_n_s;
    end
  end
endmodule

// File: rtl/divcfg_testmux.sv
module divcfg_testmux
  import divcfg_pkg::*;
(
  input  logic [T_W-1:0] sel,
  input  logic           par_mode,
  input  logic           mr_s,
  input  logic           sdata_s,
  input  logic           fb,
  input  logic           syn,
  output logic           test
);
  always_comb begin
    if (par_mode) test = 1'b0;
    else          test = test_pick(tsel_e'(sel), sdata_s, fb, syn, mr_s);
  end
endmodule

// File: rtl/synth_divcfg.sv
module synth_divcfg
  import divcfg_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 2,
  parameter int PAD_W       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_ld_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  input  logic           mrst,
  input  logic           fb_clk,
  input  logic           syn_clk,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic [T_W-1:0] t_out,
  output logic           test_out
);
  localparam int N_LSB   = M_W;
  localparam int PAD_LSB = N_LSB + N_W;
  localparam int T_LSB   = PAD_LSB + PAD_W;
  localparam int FRAME_W = T_LSB + T_W;
  localparam int PIN_W   = 5 + N_W + M_W;

  // synchronized pin bundle
  logic [PIN_W-1:0] pins_raw, pins_s, pins_p;
  assign pins_raw = {mrst, ser_ld, ser_clk, ser_dat, par_ld_n, par_n, par_m};

  divcfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s), .q_prev(pins_p)
  );

  logic           mr_s, sl_s, sl_p, sc_s, sc_p, sd_s, pl_s, pl_p;
  logic [M_W-1:0] pm_s;
  logic [N_W-1:0] pn_s;
  assign {mr_s, sl_s, sc_s, sd_s, pl_s, pn_s, pm_s} = pins_s;
  assign sl_p = pins_p[PIN_W-2];
  assign sc_p = pins_p[PIN_W-3];
  assign pl_p = pins_p[M_W+N_W];

  // named events
  logic shift_en, ser_evt, ser_latch, par_latch, live;
  assign shift_en  = pl_s & rise(sc_s, sc_p);
  assign ser_evt   = pl_s & rise(sl_s, sl_p);
  assign ser_latch = pl_s & live & fall(sl_s, sl_p);
  assign par_latch = rise(pl_s, pl_p);

  always_ff @(posedge clk) begin
    if (!rst_n)          live <= 1'b0;
    else if (!pl_s)      live <= 1'b0;
    else if (ser_evt)    live <= 1'b1;
    else if (ser_latch)  live <= 1'b0;
  end

  logic [FRAME_W-1:0] sreg;
  divcfg_shreg #(.FRAME_W(FRAME_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(sd_s), .sreg(sreg)
  );

  logic [M_W-1:0] frm_m, hold_m;
  logic [N_W-1:0] frm_n, hold_n;
  logic [T_W-1:0] frm_t, hold_t;
  assign frm_m = sreg[M_W-1:0];
  assign frm_n = sreg[PAD_LSB-1:N_LSB];
  assign frm_t = sreg[FRAME_W-1:T_LSB];

  divcfg_store #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_store (
    .clk(clk), .rst_n(rst_n), .raw_m(par_m), .raw_n(par_n),
    .par_latch(par_latch), .par_m_s(pm_s), .par_n_s(pn_s),
    .ser_latch(ser_latch), .frm_m(frm_m), .frm_n(frm_n), .frm_t(frm_t),
    .hold_m(hold_m), .hold_n(hold_n), .hold_t(hold_t)
  );

  always_comb begin
    if (!pl_s) begin
      m_out = pm_s;
      n_out = pn_s;
      t_out = hold_t;
    end else if (live) begin
      m_out = frm_m;
      n_out = frm_n;
      t_out = frm_t;
    end else begin
      m_out = hold_m;
      n_out = hold_n;
      t_out = hold_t;
    end
  end

  divcfg_testmux u_tmux (
    .sel(t_out), .par_mode(~pl_s), .mr_s(mr_s), .sdata_s(sd_s),
    .fb(fb_clk), .syn(syn_clk), .test(test_out)
  );
endmodule

// File: rtl/divcfg_chk.sv
module divcfg_chk #(
  parameter int M_W     = 9,
  parameter int N_W     = 2,
  parameter int FRAME_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pl_s,
  input logic               mr_s,
  input logic               sd_s,
  input logic               shift_en,
  input logic               ser_latch,
  input logic               par_latch,
  input logic               live,
  input logic [FRAME_W-1:0] sreg,
  input logic [M_W-1:0]     m_out,
  input logic [N_W-1:0]     n_out,
  input logic [1:0]         t_out,
  input logic               test_out
);
  logic armed, was_rst;
  always_ff @(posedge clk) begin
    armed   <= rst_n;
    was_rst <= ~rst_n;
  end

  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sreg[0] == $past(sd_s)) &&
                 (sreg[FRAME_W-1:1] == $past(sreg[FRAME_W-2:0])));

  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !pl_s) |=> $stable(sreg));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && pl_s && !live && $past(pl_s) && !$past(live) &&
     !$past(par_latch) && !$past(ser_latch))
    |-> ($stable(m_out) && $stable(n_out) && $stable(t_out)));

  p_ser_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_latch |=> (!pl_s || ((m_out == $past(sreg[M_W-1:0])) &&
                             (t_out == $past(sreg[FRAME_W-1:FRAME_W-2])))));

  p_test_par_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |-> !test_out);

  p_mr_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_s && t_out[1]) |-> !test_out);

  always @(posedge clk) begin
    if (was_rst && rst_n)
      a_treset_r10: assert (t_out == 2'b00);
  end
endmodule

bind synth_divcfg divcfg_chk #(.M_W(M_W), .N_W(N_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pl_s(pl_s), .mr_s(mr_s), .sd_s(sd_s),
  .shift_en(shift_en), .ser_latch(ser_latch), .par_latch(par_latch),
  .live(live), .sreg(sreg), .m_out(m_out), .n_out(n_out), .t_out(t_out),
  .test_out(test_out)
);

// File: tb/tb_synth_divcfg.sv
`timescale 1ns/1ps
module tb_synth_divcfg;
  logic clk = 0, rst_n = 0;
  logic par_ld_n = 1, ser_clk = 0, ser_dat = 0, ser_ld = 0, mrst = 0;
  logic fb_clk = 0, syn_clk = 0;
  logic [8:0] par_m = 9'd25;
  logic [1:0] par_n = 2'd1;
  logic [8:0] m_out;
  logic [1:0] n_out, t_out;
  logic test_out;

  always #10 clk = ~clk;

  synth_divcfg dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // ---------- behavioural reference model ----------
  typedef struct packed {
    logic mr, sl, sc, sd, pl;
    logic [1:0] pn;
    logic [8:0] pm;
  } pins_t;
  pins_t h[$];
  pins_t cur, a, b, c;
  int msr, hm, hn, ht, em, en, et, etst, oldf;
  bit mlive = 0, mchk = 0;

  always @(posedge clk) begin
    cur = '{mrst, ser_ld, ser_clk, ser_dat, par_ld_n, par_n, par_m};
    if (!rst_n) begin
      h = '{cur, cur, cur, cur};
      hm = par_m; hn = par_n; ht = 0; msr = 0; mlive = 0; mchk = 0;
    end else begin
      h.push_front(cur);
      void'(h.pop_back());
      a = h[2]; b = h[3];
      oldf = msr;
      if (!a.pl) mlive = 0;
      else begin
        if (a.sc && !b.sc) msr = ((msr * 2) + a.sd) % 16384;
        if (!b.pl) begin hm = a.pm; hn = a.pn; end
        if (a.sl && !b.sl) mlive = 1;
        else if (!a.sl && b.sl) begin
          if (mlive) begin hm = oldf % 512; hn = (oldf / 512) % 4; ht = oldf / 4096; end
          mlive = 0;
        end
      end
      mchk = 1;
    end
    #5;
    if (mchk && rst_n) begin
      c = h[1];
      if (!c.pl) begin em = c.pm; en = c.pn; et = ht; end
      else if (mlive) begin em = msr % 512; en = (msr / 512) % 4; et = msr / 4096; end
      else begin em = hm; en = hn; et = ht; end
      if (!c.pl) etst = 0;
      else case (et)
        1: etst = c.sd;
        2: etst = c.mr ? 0 : fb_clk;
        3: etst = c.mr ? 0 : syn_clk;
        default: etst = 0;
      endcase
      chk(!c.pl ? "R1 model m" : (mlive ? "R4 model m" : "R2 model m"), m_out, em);
      chk(!c.pl ? "R1 model n" : (mlive ? "R4 model n" : "R6 model n"), n_out, en);
      chk(mlive ? "R4 model t" : "R5 model t", t_out, et);
      chk(!c.pl ? "R8 model test" : "R7 model test", test_out, etst);
    end
  end

  // ---------- stimulus helpers ----------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input logic v);
    ser_dat = v; tick(3);
    ser_clk = 1; tick(3);
    ser_clk = 0; tick(3);
  endtask

  int frame;
  task automatic send_frame(input int t, input int n, input int m);
    frame = t * 4096 + n * 512 + m;
    for (int i = 13; i >= 0; i--) ser_bit(frame[i]);
  endtask

  task automatic strobe_load();
    ser_ld = 1; tick(4);
    ser_ld = 0; tick(4);
  endtask

  initial begin
    // reset with serial mode and pins 25/1 (R10)
    tick(5);
    rst_n = 1; tick(4);
    chk("R10 m after reset", m_out, 25);
    chk("R10 n after reset", n_out, 1);
    chk("R10 t after reset", t_out, 0);

    // parallel transparent (R1, R8)
    par_ld_n = 0; par_m = 9'd40; par_n = 2'd2; tick(4);
    chk("R1 m transparent", m_out, 40);
    chk("R1 n transparent", n_out, 2);
    chk("R8 test in parallel", test_out, 0);
    par_m = 9'd31; tick(4);
    chk("R1 m follows", m_out, 31);

    // latch on rise (R2)
    par_ld_n = 1; tick(4);
    par_m = 9'd100; par_n = 2'd0; tick(4);
    chk("R2 m held", m_out, 31);
    chk("R2 n held", n_out, 2);

    // serial frame T=01 N=3 M=300 (R3, R4, R6)
    send_frame(1, 3, 300);
    chk("R3 not loaded before strobe", m_out, 31);
    ser_ld = 1; tick(4);
    chk("R3 m field", m_out, 300);
    chk("R3 n field", n_out, 3);
    chk("R3 t field", t_out, 1);
    ser_dat = 1; tick(4);
    chk("R7 sdata leg high", test_out, 1);
    ser_dat = 0; tick(4);
    chk("R7 sdata leg low", test_out, 0);
    ser_bit(0);
    frame = (frame * 2) % 16384;
    chk("R4 m live shift", m_out, frame % 512);
    chk("R4 n live shift", n_out, (frame / 512) % 4);
    chk("R4 t live shift", t_out, frame / 4096);
    ser_ld = 0; tick(4);
    ser_bit(1); ser_bit(1);
    chk("R5 m stays latched", m_out, frame % 512);
    chk("R5 t stays latched", t_out, frame / 4096);
    chk("R6 serial beats parallel", m_out == 100 ? 1 : 0, 0);
    frame = (frame * 4 + 3) % 16384;

    // shifts in parallel mode are ignored (R11)
    par_ld_n = 0; par_m = 9'd77; tick(4);
    ser_bit(0); ser_bit(1); ser_bit(0);
    chk("R1 m in parallel", m_out, 77);
    chk("R8 test low", test_out, 0);
    par_ld_n = 1; tick(4);
    ser_ld = 1; tick(4);
    chk("R11 register untouched m", m_out, frame % 512);
    chk("R11 register untouched t", t_out, frame / 4096);
    ser_ld = 0; tick(4);

    // feedback leg and master reset (R7, R9)
    send_frame(2, 0, 123);
    strobe_load();
    chk("R7 t=10", t_out, 2);
    fb_clk = 1; tick(2);
    chk("R7 fb leg high", test_out, 1);
    fb_clk = 0; tick(2);
    chk("R7 fb leg low", test_out, 0);
    mrst = 1; fb_clk = 1; tick(4);
    chk("R9 test gated", test_out, 0);
    chk("R9 m kept", m_out, 123);
    chk("R9 t kept", t_out, 2);
    mrst = 0; tick(4);
    chk("R9 gate released", test_out, 1);

    // synthesized clock leg
    send_frame(3, 1, 7);
    strobe_load();
    syn_clk = 1; tick(2);
    chk("R7 syn leg high", test_out, 1);
    syn_clk = 0; tick(2);
    chk("R7 syn leg low", test_out, 0);

    // constant low leg
    send_frame(0, 2, 511);
    strobe_load();
    ser_dat = 1; fb_clk = 1; syn_clk = 1; tick(4);
    chk("R7 low leg", test_out, 0);
    chk("R3 m max", m_out, 511);

    tick(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule